// File: doc/BRIEF.md
# Dot-Matrix Display Frame Capture

This block listens, without driving anything, to the serial stream that refreshes a 128x32 monochrome dot-matrix display and rebuilds each complete picture in an on-chip frame store. Six control and data lines are watched: an enable for the display, a first-row marker, a row step clock, a line commit strobe, a pixel shift clock and the serial pixel bit. All six are asynchronous to the system clock. Each is brought into the system domain through a two-stage synchroniser, and the clocks are turned into single-cycle rising-edge events.

Pixel bits gather in a line shifter, one bit per shift clock. The shifter keeps its contents through the long idle stretches between bursts. A commit strobe copies the gathered line into the row that the row tracker currently points at. The row tracker moves forward on each row step. When the marker is high at a row step, the tracker goes back to row 0. Nothing is stored until the first marker after reset has been seen.

Each frame is built in a hidden bank. When the last row is committed, the banks swap and a one-cycle done pulse is raised. The read port therefore only ever shows finished frames.

Top module: `dfc_frame_capture`

## Requirements
- R1: After reset, frame_done_o is low and capture is disarmed.
- R2: Each rising edge of shift_clk_i shifts in the bit on pix_i. After 128 shifts, the first bit received sits at column 0 (rd_line_o bit 0) and the last bit at column 127 (bit 127).
- R3: The line shifter keeps its contents through any idle gap in shift_clk_i activity, however long.
- R4: A rising edge of row_step_i with first_row_i low moves the current row forward by one.
- R5: A rising edge of row_step_i with first_row_i high sets the current row to 0 and arms capture. Capture stays armed until reset.
- R6: Commit strobes that occur before capture is armed have no effect. No frame_done_o pulse is raised for them.
- R7: A rising edge of line_commit_i with disp_en_i high writes the shifted line into the current row of the frame being built.
- R8: A rising edge of line_commit_i while disp_en_i is low is ignored. The row keeps the line committed earlier.
- R9: A commit on row 31 raises frame_done_o for exactly one cycle and makes the finished frame readable.
- R10: While a new frame is being built, rd_line_o for every row keeps showing the last finished frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en_i | input | 1 | Display enable line; qualifies commits |
| first_row_i | input | 1 | First-row marker, sampled at a row step |
| row_step_i | input | 1 | Row step clock |
| line_commit_i | input | 1 | Line commit strobe |
| shift_clk_i | input | 1 | Pixel shift clock |
| pix_i | input | 1 | Serial pixel bit |
| rd_row_i | input | 5 | Row to read from the finished frame |
| rd_line_o | output | 128 | 128 pixels of the selected row; bit n is column n |
| frame_done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bench first plays a whole frame with no marker. This shows whether commits are wrongly accepted before capture is armed. It then sends two frames with different arithmetic pixel patterns, checking every row, so that a wrong bit order, a wrong row placement or a missed row step each shows up as a mismatch. One line is split by a long pause mid-burst, which tests whether the shifter holds its contents through the gap. Another row is followed by a junk line committed with the display disabled, which exposes any commit that ignores the enable. A half-built second frame, then a marker restart, shows whether the read side leaks partial frames and whether the marker resynchronises the row.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int unsigned DFC_COLS = 128;
  localparam int unsigned DFC_ROWS = 32;

  // positions of the watched lines inside the synchroniser bus
  localparam int unsigned LN_EN     = 0;
  localparam int unsigned LN_MARK   = 1;
  localparam int unsigned LN_STEP   = 2;
  localparam int unsigned LN_COMMIT = 3;
  localparam int unsigned LN_SHIFT  = 4;
  localparam int unsigned LN_PIX    = 5;
  localparam int unsigned LN_COUNT  = 6;
endpackage

// File: rtl/dfc_sync.sv
module dfc_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, stab_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  always_comb begin
    lvl_o  = stab_q;
    rise_o = stab_q & ~prev_q;
  end
endmodule

// File: rtl/dfc_line_shift.sv
module dfc_line_shift #(
  parameter int unsigned COLS = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            bit_i,
  output logic [COLS-1:0] line_o
);
  logic [COLS-1:0] sh_q, sh_d;

  // new bits enter at the top, so the first bit ends at column 0
  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {bit_i, sh_q[COLS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign line_o = sh_q;
endmodule

// File: rtl/dfc_row_track.sv
module dfc_row_track #(
  parameter int unsigned ROWS = 32,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          marker_i,
  output logic [RW-1:0] row_o,
  output logic          armed_o
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic [RW-1:0] row_q, row_d;
  logic          armed_q, armed_d;

  always_comb begin
    row_d   = row_q;
    armed_d = armed_q;
    if (step_en) begin
      if (marker_i) begin
        row_d   = '0;
        armed_d = 1'b1;
      end else if (row_q == LAST) begin
        row_d = '0;
      end else begin
        row_d = row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      row_q   <= row_d;
      armed_q <= armed_d;
    end
  end

  assign row_o   = row_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/dfc_frame_store.sv
module dfc_frame_store #(
  parameter int unsigned COLS = 128,
  parameter int unsigned ROWS = 32,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  input  logic [COLS-1:0] wr_line,
  input  logic [RW-1:0]   rd_row,
  output logic [COLS-1:0] rd_line,
  output logic            sel_o
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic [COLS-1:0] bank_q [2][ROWS];
  logic            sel_q, sel_d;
  logic            swap;

  always_comb begin
    swap  = wr_en && (wr_row == LAST);
    sel_d = swap ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  // storage array: write-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) bank_q[sel_q][wr_row] <= wr_line;
  end

  assign rd_line = bank_q[~sel_q][rd_row];
  assign sel_o   = sel_q;
endmodule

// File: rtl/dfc_frame_capture.sv
module dfc_frame_capture
  import dfc_pkg::*;
#(
  parameter int unsigned COLS = DFC_COLS,
  parameter int unsigned ROWS = DFC_ROWS,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_en_i,
  input  logic            first_row_i,
  input  logic            row_step_i,
  input  logic            line_commit_i,
  input  logic            shift_clk_i,
  input  logic            pix_i,
  input  logic [RW-1:0]   rd_row_i,
  output logic [COLS-1:0] rd_line_o,
  output logic            frame_done_o
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic [LN_COUNT-1:0] raw, lvl, rise;
  logic [COLS-1:0]     line;
  logic [RW-1:0]       row_q;
  logic                armed_q, commit_ok, store_sel;
  logic                done_q, done_d;

  always_comb begin
    raw            = '0;
    raw[LN_EN]     = disp_en_i;
    raw[LN_MARK]   = first_row_i;
    raw[LN_STEP]   = row_step_i;
    raw[LN_COMMIT] = line_commit_i;
    raw[LN_SHIFT]  = shift_clk_i;
    raw[LN_PIX]    = pix_i;
  end

  dfc_sync #(.W(LN_COUNT)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .lvl_o(lvl), .rise_o(rise)
  );

  dfc_line_shift #(.COLS(COLS)) i_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(rise[LN_SHIFT]),
    .bit_i(lvl[LN_PIX]), .line_o(line)
  );

  dfc_row_track #(.ROWS(ROWS)) i_rows (
    .clk(clk), .rst_n(rst_n), .step_en(rise[LN_STEP]),
    .marker_i(lvl[LN_MARK]), .row_o(row_q), .armed_o(armed_q)
  );

  always_comb begin
    commit_ok = rise[LN_COMMIT] && lvl[LN_EN] && armed_q;
    done_d    = commit_ok && (row_q == LAST);
  end

  dfc_frame_store #(.COLS(COLS), .ROWS(ROWS)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_ok), .wr_row(row_q),
    .wr_line(line), .rd_row(rd_row_i), .rd_line(rd_line_o), .sel_o(store_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign frame_done_o = done_q;
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker #(
  parameter int unsigned ROWS = 32,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_done,
  input logic [RW-1:0] row,
  input logic          armed,
  input logic          commit,
  input logic          step,
  input logic          marker,
  input logic          bank_sel
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r9_done_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> bank_sel != $past(bank_sel));

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(commit) && $past(row) == LAST));

  a_r5_marker_row0: assert property (@(posedge clk) disable iff (!rst_n)
    (step && marker) |=> (row == '0 && armed));

  a_r5_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !marker && row != LAST) |=> row == $past(row) + 1'b1);

  a_r6_done_armed: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> armed);
endmodule

bind dfc_frame_capture dfc_checker #(.ROWS(ROWS)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done_o), .row(row_q),
  .armed(armed_q), .commit(commit_ok), .step(rise[dfc_pkg::LN_STEP]),
  .marker(lvl[dfc_pkg::LN_MARK]), .bank_sel(store_sel)
);

// File: tb/test_dfc_frame_capture.sv
module test_dfc_frame_capture;
  localparam int COLS = 128;
  localparam int ROWS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_en = 1'b1, first_row = 1'b0, row_step = 1'b0;
  logic commit = 1'b0, sclk = 1'b0, pix = 1'b0;
  logic [4:0] rd_row = '0;
  logic [COLS-1:0] rd_line;
  logic frame_done;

  int total = 0, bad = 0, done_cnt = 0, run = 0, max_run = 0;

  always #10 clk = ~clk;

  dfc_frame_capture i_dfc_frame_capture (
    .clk(clk), .rst_n(rst_n), .disp_en_i(disp_en), .first_row_i(first_row),
    .row_step_i(row_step), .line_commit_i(commit), .shift_clk_i(sclk),
    .pix_i(pix), .rd_row_i(rd_row), .rd_line_o(rd_line), .frame_done_o(frame_done)
  );

  always @(negedge clk) begin
    if (rst_n && frame_done) begin
      if (run == 0) done_cnt++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  function automatic logic exp_bit(int f, int r, int c);
    return ((c * 3 + r * 7 + f * 13) % 5) < 2;
  endfunction

  function automatic logic [COLS-1:0] exp_line(int f, int r);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++) v[c] = exp_bit(f, r, c);
    return v;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [COLS-1:0] act, logic [COLS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_line(int f, int r, int gap);
    for (int c = 0; c < COLS; c++) begin
      pix = exp_bit(f, r, c);
      wait_cyc(1);
      sclk = 1'b1;
      wait_cyc(2);
      sclk = 1'b0;
      wait_cyc(1);
      if (gap > 0 && c == COLS / 2 - 1) wait_cyc(gap);
    end
  endtask

  task automatic pulse_commit();
    wait_cyc(2);
    commit = 1'b1;
    wait_cyc(3);
    commit = 1'b0;
    wait_cyc(3);
  endtask

  task automatic pulse_step(logic mark);
    first_row = mark;
    wait_cyc(2);
    row_step = 1'b1;
    wait_cyc(3);
    row_step = 1'b0;
    wait_cyc(3);
    first_row = 1'b0;
  endtask

  // plays rows 0..last_row of frame f; the first row follows a marker step
  task automatic play_frame(int f, int last_row, logic mark);
    pulse_step(mark);
    for (int r = 0; r <= last_row; r++) begin
      send_line(f, r, (r == 5) ? 3000 : 0);
      pulse_commit();
      if (r == 9) begin
        send_line(99, r, 0);
        disp_en = 1'b0;
        pulse_commit();
        disp_en = 1'b1;
      end
      if (r != ROWS - 1) pulse_step(1'b0);
    end
  endtask

  task automatic check_frame(string req, int f);
    for (int r = 0; r < ROWS; r++) begin
      rd_row = 5'(r);
      wait_cyc(1);
      check(req, rd_line, exp_line(f, r));
    end
  endtask

  initial begin
    #3_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1: reset state
    check("R1 done low in reset", {127'd0, frame_done}, '0);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1 done low after reset", {127'd0, frame_done}, '0);

    // R6: whole frame with no marker is discarded
    play_frame(7, ROWS - 1, 1'b0);
    wait_cyc(6);
    check("R6 no done before marker", COLS'(done_cnt), '0);

    // frame A with marker: R2 R3 R4 R5 R7 R8 R9
    play_frame(1, ROWS - 1, 1'b1);
    wait_cyc(6);
    check("R9 one done pulse", COLS'(done_cnt), COLS'(1));
    check("R9 pulse one cycle", COLS'(max_run), COLS'(1));
    rd_row = 5'd0;
    wait_cyc(1);
    check("R2 column 0 first bit", {127'd0, rd_line[0]}, {127'd0, exp_bit(1, 0, 0)});
    check("R2 column 127 last bit", {127'd0, rd_line[COLS-1]}, {127'd0, exp_bit(1, 0, COLS - 1)});
    rd_row = 5'd5;
    wait_cyc(1);
    check("R3 line across idle gap", rd_line, exp_line(1, 5));
    rd_row = 5'd9;
    wait_cyc(1);
    check("R8 disabled commit ignored", rd_line, exp_line(1, 9));
    check_frame("R4 R7 frame A rows", 1);

    // R10: half-built frame B stays hidden
    play_frame(2, 9, 1'b1);
    wait_cyc(6);
    check("R10 no done for partial", COLS'(done_cnt), COLS'(1));
    check_frame("R10 partial frame hidden", 1);

    // R5: marker restarts the row count mid-frame
    play_frame(2, ROWS - 1, 1'b1);
    wait_cyc(6);
    check("R9 second done", COLS'(done_cnt), COLS'(2));
    check_frame("R5 resync frame B rows", 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule